// File: doc/BRIEF.md
# Indirect Dword Window onto a Controller Register File

This block places an 8-byte capability in a device's configuration space. Through it, software can reach a larger register file that belongs to a hot-plug controller. One byte of the capability selects a dword index n. A 32-bit data register in the capability then mirrors controller bytes 4n to 4n+3. Software that can only issue configuration cycles reaches every controller register this way. It writes the index first, then reads or writes the data register.

The data register is a cached copy. It is refreshed one clock after every write that lands in the capability. A write to the data register sends the whole 32-bit value to the controller at byte 4n. The controller applies it one byte at a time, through a fixed write mask and a fixed write-one-to-clear mask per byte. The controller's own hardware updates its bytes through a separate raw port, which bypasses the masks and does not refresh the window. The register file holds 36 + 4 × NSLOTS bytes. Anything past that end reads as zero and takes no writes.

Top module: `capwin_window`

## Requirements
- R1: After reset: the select byte is 0, the data register is 0, and every controller byte is 0. A read of the first capability dword returns {8'h00, 8'h00, NEXT_PTR, CAP_ID}.
- R2: Layout of configuration dword CAP_DW:
  - byte lane 2 is the select byte; all 8 bits are writable;
  - lane 0 returns CAP_ID and lane 1 returns NEXT_PTR, and both ignore writes;
  - lane 3 reads 0 and ignores writes.
- R3: A read of configuration dword CAP_DW+1 returns controller bytes 4n..4n+3, where n is the select value. Byte 4n+i appears on lane i (little-endian).
- R4: A write to dword CAP_DW+1 builds a full 32-bit value: enabled lanes take the written byte, other lanes keep the current data-register content. That value is sent to controller byte address 4n on the same clock edge and becomes the new data-register content.
- R5: Each forwarded byte becomes (old & ~wm) | (d & wm), and then the bits of d & w1c are cleared. Bytes with a nonzero mask:
  - byte 0x14: wm 0xFF;
  - byte 0x15: wm 0x1F;
  - byte 0x20: wm 0x0F;
  - byte 0x22: w1c 0x03;
  - for each slot s below NSLOTS, byte 0x24+4s+2: w1c 0x1F;
  - for each slot s below NSLOTS, byte 0x24+4s+3: wm 0x7F.

  Every other byte has both masks 0, so it is read-only through the window.
- R6: Any write that touches dword CAP_DW or CAP_DW+1 reloads the data register from the controller at the (new) select value on the next edge. A read in the cycle right after such a write, and any read after that, sees the contents as they stand after the write. This holds for back-to-back writes as well.
- R7: Hardware writes on the hw_* port store the enabled bytes of hw_wdata without masks. hw_rdata returns controller dword hw_addr. A hardware write does not change what the window data register reads until the next write into the capability.
- R8: When a hardware write and a forwarded write hit the same byte on the same edge, the hardware value is applied first. The masked forwarded write is then applied on top of it.
- R9: When 4n is at or beyond the register-file size, the data register reads 0 and a forwarded write changes no controller byte.
- R10: Configuration writes to any dword other than CAP_DW and CAP_DW+1 are ignored and do not trigger a reload. Configuration reads of those dwords return 0.
- R11: Hardware reads of a dword at or beyond the register-file size return 0, and hardware writes there change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Configuration dword address |
| cfg_be | input | 4 | Configuration write byte enables |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for cfg_addr |
| hw_we | input | 1 | Controller-side raw write strobe |
| hw_addr | input | HW_AW | Controller-side dword address |
| hw_be | input | 4 | Controller-side byte enables |
| hw_wdata | input | 32 | Controller-side write data |
| hw_rdata | output | 32 | Controller register dword at hw_addr |

## Verification
Two paths can write the same controller byte on one edge: a raw hardware write and a masked write forwarded from the window. The bench provokes this on purpose with a single directed cycle that drives both ports at the same dword. It then checks the stored byte against the hardware-then-mask order, using hand-computed constants. The reload of the data register can also fall in the same cycle as a new data write, when two window writes come back to back; here the merge has to start from the freshly reloaded contents. Both cases are also hit at random, and a behavioural model of the register file, the select byte and the mirror judges every cycle.

// File: rtl/capwin_pkg.sv
package capwin_pkg;

   // first byte of the per-slot area; slot s uses four bytes from here
   localparam int unsigned SLOT_AREA = 36;

   function automatic int unsigned file_bytes(input int unsigned nslots);
      return SLOT_AREA + 4 * nslots;
   endfunction

   function automatic logic [7:0] wmask_of(input int unsigned a, input int unsigned nslots);
      logic [7:0] m;
      m = 8'h00;
      if (a == 20)      m = 8'hFF;
      else if (a == 21) m = 8'h1F;
      else if (a == 32) m = 8'h0F;
      else if (a >= SLOT_AREA && a < file_bytes(nslots) && (a % 4) == 3) m = 8'h7F;
      return m;
   endfunction

   function automatic logic [7:0] w1cmask_of(input int unsigned a, input int unsigned nslots);
      logic [7:0] m;
      m = 8'h00;
      if (a == 34) m = 8'h03;
      else if (a >= SLOT_AREA && a < file_bytes(nslots) && (a % 4) == 2) m = 8'h1F;
      return m;
   endfunction

endpackage

// File: rtl/capwin_byte_cell.sv
module capwin_byte_cell #(
   parameter logic [7:0] WMASK   = 8'h00,
   parameter logic [7:0] W1CMASK = 8'h00
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hw_hit,
   input  logic [7:0] hw_byte,
   input  logic       fw_hit,
   input  logic [7:0] fw_byte,
   output logic [7:0] q
);

   localparam bit HAS_MASK = (WMASK != 8'h00) || (W1CMASK != 8'h00);

   generate
      if ((WMASK & W1CMASK) != 8'h00) begin : g_bad_masks
         $error("capwin_byte_cell: write and clear masks overlap");
      end
   endgenerate

   logic [7:0] after_hw;
   logic [7:0] nxt;

   always_comb begin
      after_hw = hw_hit ? hw_byte : q;
   end

   generate
      if (HAS_MASK) begin : g_masked
         always_comb begin
            nxt = after_hw;
            if (fw_hit) begin
               nxt = (after_hw & ~WMASK) | (fw_byte & WMASK);
               nxt = nxt & ~(fw_byte & W1CMASK);
            end
         end
      end else begin : g_readonly
         logic unused_fw;
         assign unused_fw = fw_hit ^ (^fw_byte);
         always_comb nxt = after_hw;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 8'h00;
      else        q <= nxt;
   end

endmodule

// File: rtl/capwin_regfile.sv
module capwin_regfile #(
   parameter int unsigned NSLOTS = 4,
   parameter int unsigned HW_AW  = 8,
   parameter int unsigned SEL_W  = 8,
   localparam int unsigned NB    = capwin_pkg::file_bytes(NSLOTS),
   localparam int unsigned NDW   = NB / 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hw_we,
   input  logic [HW_AW-1:0]  hw_dw,
   input  logic [3:0]        hw_be,
   input  logic [31:0]       hw_wdata,
   output logic [31:0]       hw_rdata,
   input  logic              fw_en,
   input  logic [SEL_W-1:0]  fw_dw,
   input  logic [31:0]       fw_data,
   output logic [31:0]       fresh,
   output logic [NB*8-1:0]   mem_flat
);

   generate
      if (NDW > (1 << HW_AW)) begin : g_bad_aw
         $error("capwin_regfile: HW_AW too narrow for the register file");
      end
   endgenerate

   for (genvar k = 0; k < NB; k++) begin : g_byte
      localparam int unsigned DW = k / 4;
      localparam int unsigned LN = k % 4;
      logic hw_hit;
      logic fw_hit;
      assign hw_hit = hw_we && (hw_dw == HW_AW'(DW)) && hw_be[LN];
      assign fw_hit = fw_en && (fw_dw == SEL_W'(DW));
      capwin_byte_cell #(
         .WMASK   (capwin_pkg::wmask_of(k, NSLOTS)),
         .W1CMASK (capwin_pkg::w1cmask_of(k, NSLOTS))
      ) u_cell (
         .clk     (clk),
         .rst_n   (rst_n),
         .hw_hit  (hw_hit),
         .hw_byte (hw_wdata[LN*8 +: 8]),
         .fw_hit  (fw_hit),
         .fw_byte (fw_data[LN*8 +: 8]),
         .q       (mem_flat[k*8 +: 8])
      );
   end

   always_comb begin
      fresh    = 32'h0;
      hw_rdata = 32'h0;
      for (int d = 0; d < NDW; d++) begin
         if (fw_dw == SEL_W'(d)) fresh    = mem_flat[d*32 +: 32];
         if (hw_dw == HW_AW'(d)) hw_rdata = mem_flat[d*32 +: 32];
      end
   end

endmodule

// File: rtl/capwin_cfg_port.sv
module capwin_cfg_port #(
   parameter int unsigned CFG_AW   = 6,
   parameter int unsigned CAP_DW   = 16,
   parameter logic [7:0]  CAP_ID   = 8'h0C,
   parameter logic [7:0]  NEXT_PTR = 8'h00,
   localparam int unsigned SEL_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [3:0]        cfg_be,
   input  logic [31:0]       cfg_wdata,
   output logic [31:0]       cfg_rdata,
   input  logic [31:0]       fresh,
   output logic [SEL_W-1:0]  sel_o,
   output logic              fw_en,
   output logic [31:0]       fw_data,
   output logic [31:0]       mirror_o,
   output logic              reload_o
);

   logic [SEL_W-1:0] sel_q;
   logic [31:0]      data_q;
   logic             reload_q;
   logic             hit_hdr;
   logic             hit_dat;
   logic [31:0]      eff;
   logic [31:0]      merged;

   assign hit_hdr = (cfg_addr == CFG_AW'(CAP_DW));
   assign hit_dat = (cfg_addr == CFG_AW'(CAP_DW + 1));

   // a pending reload wins over the stale copy for both reads and merges
   assign eff = reload_q ? fresh : data_q;

   for (genvar i = 0; i < 4; i++) begin : g_lane
      assign merged[i*8 +: 8] = cfg_be[i] ? cfg_wdata[i*8 +: 8] : eff[i*8 +: 8];
   end

   assign fw_en   = cfg_we && hit_dat;
   assign fw_data = merged;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q    <= '0;
         data_q   <= 32'h0;
         reload_q <= 1'b0;
      end else begin
         if (cfg_we && hit_hdr && cfg_be[2]) sel_q <= cfg_wdata[23:16];
         data_q   <= fw_en ? merged : eff;
         reload_q <= cfg_we && (hit_hdr || hit_dat);
      end
   end

   always_comb begin
      if (hit_hdr)      cfg_rdata = {8'h00, sel_q, NEXT_PTR, CAP_ID};
      else if (hit_dat) cfg_rdata = eff;
      else              cfg_rdata = 32'h0;
   end

   assign sel_o    = sel_q;
   assign mirror_o = data_q;
   assign reload_o = reload_q;

endmodule

// File: rtl/capwin_window.sv
module capwin_window #(
   parameter int unsigned NSLOTS   = 4,
   parameter int unsigned CFG_AW   = 6,
   parameter int unsigned CAP_DW   = 16,
   parameter logic [7:0]  CAP_ID   = 8'h0C,
   parameter logic [7:0]  NEXT_PTR = 8'h00,
   parameter int unsigned HW_AW    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [3:0]        cfg_be,
   input  logic [31:0]       cfg_wdata,
   output logic [31:0]       cfg_rdata,
   input  logic              hw_we,
   input  logic [HW_AW-1:0]  hw_addr,
   input  logic [3:0]        hw_be,
   input  logic [31:0]       hw_wdata,
   output logic [31:0]       hw_rdata
);

   localparam int unsigned SEL_W  = 8;
   localparam int unsigned NB_TOP = capwin_pkg::file_bytes(NSLOTS);

   generate
      if (NSLOTS < 1 || NSLOTS > 31) begin : g_bad_slots
         $error("capwin_window: NSLOTS must lie in 1..31");
      end
      if (CAP_DW + 2 > (1 << CFG_AW)) begin : g_bad_cap
         $error("capwin_window: capability does not fit the config space");
      end
   endgenerate

   logic [SEL_W-1:0]  sel_w;
   logic              fw_en_w;
   logic [31:0]       fw_data_w;
   logic [31:0]       fresh_w;
   logic [31:0]       mirror_w;
   logic              reload_w;
   logic [NB_TOP*8-1:0] mem_flat;

   capwin_cfg_port #(
      .CFG_AW   (CFG_AW),
      .CAP_DW   (CAP_DW),
      .CAP_ID   (CAP_ID),
      .NEXT_PTR (NEXT_PTR)
   ) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_be    (cfg_be),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .fresh     (fresh_w),
      .sel_o     (sel_w),
      .fw_en     (fw_en_w),
      .fw_data   (fw_data_w),
      .mirror_o  (mirror_w),
      .reload_o  (reload_w)
   );

   capwin_regfile #(
      .NSLOTS (NSLOTS),
      .HW_AW  (HW_AW),
      .SEL_W  (SEL_W)
   ) u_file (
      .clk      (clk),
      .rst_n    (rst_n),
      .hw_we    (hw_we),
      .hw_dw    (hw_addr),
      .hw_be    (hw_be),
      .hw_wdata (hw_wdata),
      .hw_rdata (hw_rdata),
      .fw_en    (fw_en_w),
      .fw_dw    (sel_w),
      .fw_data  (fw_data_w),
      .fresh    (fresh_w),
      .mem_flat (mem_flat)
   );

endmodule

// File: rtl/capwin_window_chk.sv
module capwin_window_chk #(
   parameter int unsigned CFG_AW = 6,
   parameter int unsigned CAP_DW = 16,
   parameter int unsigned NB     = 52
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_we,
   input logic [CFG_AW-1:0] cfg_addr,
   input logic [3:0]        cfg_be,
   input logic [31:0]       cfg_wdata,
   input logic [7:0]        sel_w,
   input logic              reload_w,
   input logic [31:0]       mirror_w,
   input logic              fw_en_w,
   input logic              hw_we,
   input logic [NB*8-1:0]   mem_flat
);

   logic sel_wr;
   logic cap_wr;
   logic dat_wr;
   assign sel_wr = cfg_we && (cfg_addr == CFG_AW'(CAP_DW)) && cfg_be[2];
   assign dat_wr = cfg_we && (cfg_addr == CFG_AW'(CAP_DW + 1));
   assign cap_wr = dat_wr || (cfg_we && (cfg_addr == CFG_AW'(CAP_DW)));

   // R2
   sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_wr |=> $stable(sel_w));

   // R2
   sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel_wr |=> (sel_w == $past(cfg_wdata[23:16])));

   // R6
   reload_after_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_wr |=> reload_w);

   // R10
   no_stray_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_wr |=> !reload_w);

   // R10
   mirror_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!dat_wr && !reload_w) |=> $stable(mirror_w));

   // R5
   file_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hw_we && !fw_en_w) |=> $stable(mem_flat));

   // R9
   fwd_oob_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hw_we && fw_en_w && (int'(sel_w) >= NB / 4)) |=> $stable(mem_flat));

endmodule

bind capwin_window capwin_window_chk #(
   .CFG_AW (CFG_AW),
   .CAP_DW (CAP_DW),
   .NB     (NB_TOP)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_we    (cfg_we),
   .cfg_addr  (cfg_addr),
   .cfg_be    (cfg_be),
   .cfg_wdata (cfg_wdata),
   .sel_w     (sel_w),
   .reload_w  (reload_w),
   .mirror_w  (mirror_w),
   .fw_en_w   (fw_en_w),
   .hw_we     (hw_we),
   .mem_flat  (mem_flat)
);

// File: tb/tb_capwin_window.sv
module tb_capwin_window;

   localparam int NSL  = 4;
   localparam int NB   = 36 + 4 * NSL;
   localparam int CAW  = 6;
   localparam int CDW  = 16;
   localparam int HAW  = 8;
   localparam logic [7:0] CID = 8'h0C;
   localparam logic [7:0] NXT = 8'h00;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_we = 1'b0;
   logic [CAW-1:0] cfg_addr = '0;
   logic [3:0] cfg_be = 4'h0;
   logic [31:0] cfg_wdata = 32'h0;
   logic [31:0] cfg_rdata;
   logic hw_we = 1'b0;
   logic [HAW-1:0] hw_addr = '0;
   logic [3:0] hw_be = 4'h0;
   logic [31:0] hw_wdata = 32'h0;
   logic [31:0] hw_rdata;

   always #2 clk = ~clk;

   capwin_window dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .hw_we(hw_we), .hw_addr(hw_addr), .hw_be(hw_be),
      .hw_wdata(hw_wdata), .hw_rdata(hw_rdata)
   );

   int checks = 0;
   int failures = 0;
   string cur_req = "R1";
   bit done = 0;

   // behavioural reference
   logic [7:0]  m [NB];
   logic [7:0]  msel;
   logic [31:0] mdata;
   bit          mrl;

   function automatic logic [7:0] ref_wm(input int a);
      if (a == 'h14) return 8'hFF;
      if (a == 'h15) return 8'h1F;
      if (a == 'h20) return 8'h0F;
      if (a >= 'h24 && a < NB && a % 4 == 3) return 8'h7F;
      return 8'h00;
   endfunction

   function automatic logic [7:0] ref_w1(input int a);
      if (a == 'h22) return 8'h03;
      if (a >= 'h24 && a < NB && a % 4 == 2) return 8'h1F;
      return 8'h00;
   endfunction

   function automatic logic [31:0] ref_rd(input int dw);
      logic [31:0] v;
      v = 32'h0;
      if (dw * 4 + 3 < NB)
         for (int i = 0; i < 4; i++) v[i*8 +: 8] = m[dw*4 + i];
      return v;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int a = 0; a < NB; a++) m[a] = 8'h00;
         msel = 8'h00; mdata = 32'h0; mrl = 0;
      end else begin
         logic [31:0] eff;
         logic [31:0] mg;
         logic [7:0]  nsel;
         eff = mrl ? ref_rd(int'(msel)) : mdata;
         if (hw_we)
            for (int i = 0; i < 4; i++)
               if (hw_be[i] && int'(hw_addr) * 4 + i < NB) m[int'(hw_addr)*4 + i] = hw_wdata[i*8 +: 8];
         nsel = msel;
         if (cfg_we && cfg_addr == CAW'(CDW) && cfg_be[2]) nsel = cfg_wdata[23:16];
         if (cfg_we && cfg_addr == CAW'(CDW + 1)) begin
            for (int i = 0; i < 4; i++) mg[i*8 +: 8] = cfg_be[i] ? cfg_wdata[i*8 +: 8] : eff[i*8 +: 8];
            for (int i = 0; i < 4; i++) begin
               int a;
               a = int'(msel) * 4 + i;
               if (a < NB) begin
                  m[a] = (m[a] & ~ref_wm(a)) | (mg[i*8 +: 8] & ref_wm(a));
                  m[a] = m[a] & ~(mg[i*8 +: 8] & ref_w1(a));
               end
            end
            mdata = mg;
         end else begin
            mdata = eff;
         end
         mrl = cfg_we && (cfg_addr == CAW'(CDW) || cfg_addr == CAW'(CDW + 1));
         msel = nsel;
      end
   end

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
      end
   endtask

   // cycle-by-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic [31:0] ec;
         if (cfg_addr == CAW'(CDW)) ec = {8'h00, msel, NXT, CID};
         else if (cfg_addr == CAW'(CDW + 1)) ec = mrl ? ref_rd(int'(msel)) : mdata;
         else ec = 32'h0;
         chk(cur_req, "model cfg_rdata", cfg_rdata, ec);
         chk(cur_req, "model hw_rdata", hw_rdata, ref_rd(int'(hw_addr)));
      end
   end

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic cfg_wr(input int dw, input logic [3:0] be, input logic [31:0] d);
      cfg_we = 1; cfg_addr = CAW'(dw); cfg_be = be; cfg_wdata = d;
      step();
      cfg_we = 0;
   endtask

   task automatic hw_wr(input int dw, input logic [3:0] be, input logic [31:0] d);
      hw_we = 1; hw_addr = HAW'(dw); hw_be = be; hw_wdata = d;
      step();
      hw_we = 0;
   endtask

   task automatic look(input string tag, input int cdw, input int hdw,
                       input logic [31:0] ecfg, input logic [31:0] ehw);
      cfg_addr = CAW'(cdw); hw_addr = HAW'(hdw);
      @(negedge clk);
      chk(tag, "cfg_rdata", cfg_rdata, ecfg);
      chk(tag, "hw_rdata", hw_rdata, ehw);
      step();
   endtask

   initial begin
      repeat (3) step();
      rst_n = 1;
      // R1 reset values
      cur_req = "R1";
      look("R1", CDW, 5, 32'h0000_000C, 32'h0);
      look("R1", CDW + 1, 9, 32'h0, 32'h0);

      // R3 select and read through the window
      cur_req = "R3";
      hw_wr(5, 4'hF, 32'h1122_3344);
      cfg_wr(CDW, 4'b0100, 32'h0005_0000);
      look("R3", CDW + 1, 5, 32'h1122_3344, 32'h1122_3344);
      look("R2", CDW, 5, 32'h0005_000C, 32'h1122_3344);

      // R4 R5 full forwarded write through masks
      cur_req = "R5";
      cfg_wr(CDW + 1, 4'hF, 32'hFFFF_FFFF);
      look("R5", CDW + 1, 5, 32'h1122_3FFF, 32'h1122_3FFF);
      cur_req = "R4";
      cfg_wr(CDW + 1, 4'b0001, 32'h0000_00A5);
      look("R4", CDW + 1, 5, 32'h1122_3FA5, 32'h1122_3FA5);

      // R5 write-one-to-clear on a slot byte
      cur_req = "R5";
      hw_wr(9, 4'hF, 32'h1F1F_0000);
      cfg_wr(CDW, 4'b0100, 32'h0009_0000);
      cfg_wr(CDW + 1, 4'hF, 32'h8005_0A00);
      look("R5", CDW + 1, 9, 32'h001A_0000, 32'h001A_0000);

      // R7 raw hardware write does not refresh the window
      cur_req = "R7";
      hw_wr(9, 4'b1000, 32'h4200_0000);
      look("R7", CDW + 1, 9, 32'h001A_0000, 32'h421A_0000);
      cfg_wr(CDW, 4'b0001, 32'h0000_00EE);
      look("R6", CDW + 1, 9, 32'h421A_0000, 32'h421A_0000);

      // R8 hardware and forwarded write on the same edge
      cur_req = "R8";
      hw_we = 1; hw_addr = HAW'(9); hw_be = 4'b0100; hw_wdata = 32'h00FF_0000;
      cfg_wr(CDW + 1, 4'hF, 32'h0003_0000);
      hw_we = 0;
      look("R8", CDW + 1, 9, 32'h00FC_0000, 32'h00FC_0000);

      // R9 select beyond the file
      cur_req = "R9";
      cfg_wr(CDW, 4'b0100, 32'h00C8_0000);
      look("R9", CDW + 1, 5, 32'h0, 32'h1122_3FA5);
      cfg_wr(CDW + 1, 4'hF, 32'hFFFF_FFFF);
      look("R9", CDW + 1, 5, 32'h0, 32'h1122_3FA5);
      look("R9", CDW + 1, 8, 32'h0, 32'h0);

      // R11 hardware access past the end
      cur_req = "R11";
      hw_wr(100, 4'hF, 32'hDEAD_BEEF);
      look("R11", CDW, 100, 32'h00C8_000C, 32'h0);

      // R2 read-only lanes of the header dword
      cur_req = "R2";
      cfg_wr(CDW, 4'b1011, 32'hFFFF_FFFF);
      look("R2", CDW, 5, 32'h00C8_000C, 32'h1122_3FA5);

      // R10 stray writes do not reload
      cur_req = "R10";
      cfg_wr(CDW, 4'b0100, 32'h0005_0000);
      hw_wr(5, 4'hF, 32'h0);
      cfg_wr(CDW + 2, 4'hF, 32'hFFFF_FFFF);
      cfg_wr(CDW - 1, 4'hF, 32'hFFFF_FFFF);
      look("R10", CDW + 1, 5, 32'h1122_3FA5, 32'h0);
      look("R10", CDW + 2, 5, 32'h0, 32'h0);

      // R6 back-to-back data writes merge onto reloaded contents
      cur_req = "R6";
      cfg_wr(CDW + 1, 4'b0001, 32'h0000_00AA);
      cfg_wr(CDW + 1, 4'b0010, 32'h0000_BB00);
      look("R6", CDW + 1, 5, 32'h0000_1BAA, 32'h0000_1BAA);

      // random traffic judged by the model
      cur_req = "R4";
      for (int n = 0; n < 4000; n++) begin
         cfg_we = ($urandom % 3) == 0;
         cfg_addr = CAW'(CDW - 1 + ($urandom % 4));
         cfg_be = 4'($urandom);
         cfg_wdata = $urandom;
         if (cfg_addr == CAW'(CDW)) cfg_wdata[23:16] = 8'($urandom % 16);
         hw_we = ($urandom % 4) == 0;
         hw_addr = HAW'($urandom % 16);
         hw_be = 4'($urandom);
         hw_wdata = $urandom;
         if (n % 500 == 0) cur_req = (cur_req == "R4") ? "R8" : "R4";
         step();
      end
      cfg_we = 0; hw_we = 0;
      step();

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         failures++;
         $display("FAIL watchdog expired act=%h exp=%h", 32'h0, 32'h1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule